// File: doc/BRIEF.md
# Guest Supervisor Status Register

This block holds the status word that a guest operating system sees as its supervisor status register when a hart runs under a hypervisor. The word contains the guest's interrupt-enable bit and its saved copy. It also keeps the privilege level held before the last trap, the guest's permission bits for user-page access and executable-page reads, and the context-state fields for the floating-point and vector units. Software reaches the word through a read port and a masked write port. The CSR address decode sits outside the block.

Hardware events also update the word. A trap into guest supervisor mode saves the enable bit and the previous privilege. A return from such a trap restores them. Writes to floating-point or vector architectural state mark the matching context field as dirty. A derived dirty-summary bit sits in the top bit of the word, so its position follows the selected layout (32 or 64 bits). The user-mode XLEN field and the user-mode endianness bit are fixed by parameters.

The block also produces two qualifiers for the rest of the pipeline: whether floating-point instructions may execute, and whether guest-supervisor-level interrupts are enabled.

Top module: `guest_status_reg`

## Requirements
- R1: After reset, every writable field reads 0. The read value holds only the fixed bits: endianness at bit 6, the XLEN code at bits 33:32 in the 64-bit layout, and 0 everywhere else.
- R2: A CSR write changes only the writable fields whose bits are set in the write mask: SIE (bit 1), SPIE (bit 5), SPP (bit 8), VS (bits 10:9), FS (bits 14:13), SUM (bit 18) and MXR (bit 19). Each changed field takes the write data. Fields whose mask bits are clear keep their value.
- R3: CSR writes have no effect on XS (bits 16:15, always 0), the dirty-summary bit, the endianness bit, the XLEN field or any undefined bit.
- R4: The dirty-summary bit reads 1 exactly when FS is 3 (XS is always 0). It sits at bit 63 in the 64-bit layout and at bit 31 in the 32-bit layout. In the 64-bit layout, bit 31 reads 0.
- R5: A floating-point register write while the current mode is guest user or guest supervisor sets FS to 3 on the next clock. In host mode such a write leaves FS unchanged.
- R6: A vector register or vector CSR write sets VS to 3 on the next clock.
- R7: When a hardware dirty update and a CSR write hit FS or VS in the same cycle, the field becomes 3.
- R8: On trap entry, SPP takes the prior privilege input (0 = guest user, 1 = guest supervisor), SPIE takes the old SIE, and SIE becomes 0. A CSR write in the same cycle does not change these three fields.
- R9: On trap return, SIE takes the old SPIE and SPIE becomes 1. The return-privilege output always equals SPP.
- R10: The floating-point enable output is 0 whenever the machine-level FS input is 0. In guest user or guest supervisor mode it is also 0 when FS is 0. Otherwise it is 1.
- R11: The guest interrupt enable output is 1 in guest user mode and equals SIE in guest supervisor mode. It is 0 in host mode. Mode encoding: 0 = host, 1 = guest user, 2 = guest supervisor, 3 = host.
- R12: If trap entry and trap return are both asserted in the same cycle, trap entry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | CSR write strobe |
| csr_wdata | input | DW | CSR write data |
| csr_wmask | input | DW | Per-bit write mask |
| csr_rdata | output | DW | Assembled read value |
| cur_mode | input | 2 | Current mode: 0 host, 1 guest user, 2 guest supervisor, 3 host |
| trap_enter | input | 1 | Trap taken into guest supervisor mode |
| trap_prev_priv | input | 1 | Privilege before the trap (0 guest user, 1 guest supervisor) |
| trap_return | input | 1 | Return from a guest supervisor trap |
| fp_reg_write | input | 1 | A floating-point register or FP control register is written |
| vec_reg_write | input | 1 | A vector register or vector CSR is written |
| mach_fs | input | 2 | Machine-level FS field |
| sie_o | output | 1 | Interrupt enable |
| spie_o | output | 1 | Saved interrupt enable |
| spp_o | output | 1 | Saved previous privilege |
| fs_o | output | 2 | Floating-point context state |
| vs_o | output | 2 | Vector context state |
| sum_o | output | 1 | User-page access permission |
| mxr_o | output | 1 | Executable pages readable |
| sd_o | output | 1 | Dirty summary |
| ret_priv_o | output | 1 | Privilege to resume on trap return |
| fp_enable_o | output | 1 | Floating-point instructions allowed |
| guest_irq_en_o | output | 1 | Guest supervisor interrupts enabled |

## Verification
The bench builds the block with the 64-bit layout, an XLEN code of 1 and big-endian set. This puts the XLEN field at bits 33:32 and the summary bit at bit 63 within reach of the checks. It also shows that bit 31 stays clear. Since the endianness bit is fixed at 1, the bench can tell a hardwired bit from a reset value: a masked write of zeros has to leave that bit at 1.

// File: rtl/gsr_pkg.sv
// Shared definitions for the guest status register: field bit positions
// and the current-mode encoding. Assumes the 64-bit layout is a superset
// of the 32-bit one below bit 31.
package gsr_pkg;
    localparam int BIT_SIE  = 1;
    localparam int BIT_SPIE = 5;
    localparam int BIT_UBE  = 6;
    localparam int BIT_SPP  = 8;
    localparam int LSB_VS   = 9;
    localparam int LSB_FS   = 13;
    localparam int BIT_SUM  = 18;
    localparam int BIT_MXR  = 19;
    localparam int LSB_UXL  = 32;
    localparam int NUM_CTX  = 2;   // index 0 = FS, index 1 = VS
    localparam logic [1:0] CTX_DIRTY = 2'b11;

    typedef enum logic [1:0] {
        MODE_HOST  = 2'd0,
        MODE_GUSER = 2'd1,
        MODE_GSUP  = 2'd2,
        MODE_HOST3 = 2'd3
    } gmode_e;
endpackage

// File: rtl/gsr_ctx_field.sv
// Two-bit context-state field (FP or vector). Software may write any value
// under a mask; a hardware dirty event forces 3 and wins over software.
// Assumes synchronous active-low reset to 0.
module gsr_ctx_field (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_we,
    input  logic [1:0] sw_data,
    input  logic [1:0] sw_mask,
    input  logic       hw_dirty,
    output logic [1:0] q
);
    import gsr_pkg::*;

    // Purpose: hold the field, hardware dirty first, then masked software write.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= 2'b00;
        else if (hw_dirty) q <= CTX_DIRTY;
        else if (sw_we)    q <= (q & ~sw_mask) | (sw_data & sw_mask);
    end
endmodule

// File: rtl/gsr_stack.sv
// Interrupt-enable stack: SIE, SPIE and SPP. Trap entry beats trap return,
// and both beat a software write. Assumes the caller supplies masked-write
// enables per bit.
module gsr_stack (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_we,
    input  logic sw_sie,
    input  logic sw_sie_m,
    input  logic sw_spie,
    input  logic sw_spie_m,
    input  logic sw_spp,
    input  logic sw_spp_m,
    input  logic trap_enter,
    input  logic prev_priv,
    input  logic trap_return,
    output logic sie,
    output logic spie,
    output logic spp
);
    // Purpose: apply trap entry, trap return or software write, in that priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sie  <= 1'b0;
            spie <= 1'b0;
            spp  <= 1'b0;
        end else if (trap_enter) begin
            spp  <= prev_priv;
            spie <= sie;
            sie  <= 1'b0;
        end else if (trap_return) begin
            sie  <= spie;
            spie <= 1'b1;
        end else if (sw_we) begin
            if (sw_sie_m)  sie  <= sw_sie;
            if (sw_spie_m) spie <= sw_spie;
            if (sw_spp_m)  spp  <= sw_spp;
        end
    end
endmodule

// File: rtl/gsr_readmux.sv
// Builds the read value from the live fields and the fixed parameter bits,
// and derives the dirty summary. The summary sits in the top bit of
// whichever layout WIDE selects.
module gsr_readmux #(
    parameter bit         WIDE     = 1'b1,
    parameter logic [1:0] UXL_CODE = 2'd1,
    parameter bit         BIG_END  = 1'b0,
    localparam int        DW       = WIDE ? 64 : 32
) (
    input  logic          sie,
    input  logic          spie,
    input  logic          spp,
    input  logic [1:0]    fs,
    input  logic [1:0]    vs,
    input  logic          sum,
    input  logic          mxr,
    output logic          sd,
    output logic [DW-1:0] rdata
);
    import gsr_pkg::*;

    logic [30:0] low;

    // Purpose: the summary reflects only this register's FS (XS is fixed at 0).
    always_comb sd = (fs == CTX_DIRTY);

    // Purpose: place every field below bit 31 at its fixed position.
    always_comb begin
        low                     = '0;
        low[BIT_SIE]            = sie;
        low[BIT_SPIE]           = spie;
        low[BIT_UBE]            = BIG_END;
        low[BIT_SPP]            = spp;
        low[LSB_VS +: 2]        = vs;
        low[LSB_FS +: 2]        = fs;
        low[BIT_SUM]            = sum;
        low[BIT_MXR]            = mxr;
    end

    generate
        if (WIDE) begin : g_wide
            assign rdata = {sd, 29'd0, UXL_CODE, 1'b0, low};
        end else begin : g_narrow
            assign rdata = {sd, low};
        end
    endgenerate
endmodule

// File: rtl/guest_status_reg.sv
// Guest supervisor status register top. Connects the enable stack, the two
// context-state fields, the permission bits and the read assembly, and
// derives the FP-enable and guest-interrupt qualifiers. Assumes address
// decode is done upstream, so csr_we already means "this register".
module guest_status_reg #(
    parameter bit         WIDE     = 1'b1,
    parameter logic [1:0] UXL_CODE = 2'd1,
    parameter bit         BIG_END  = 1'b0,
    localparam int        DW       = WIDE ? 64 : 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csr_we,
    input  logic [DW-1:0] csr_wdata,
    input  logic [DW-1:0] csr_wmask,
    output logic [DW-1:0] csr_rdata,
    input  logic [1:0]    cur_mode,
    input  logic          trap_enter,
    input  logic          trap_prev_priv,
    input  logic          trap_return,
    input  logic          fp_reg_write,
    input  logic          vec_reg_write,
    input  logic [1:0]    mach_fs,
    output logic          sie_o,
    output logic          spie_o,
    output logic          spp_o,
    output logic [1:0]    fs_o,
    output logic [1:0]    vs_o,
    output logic          sum_o,
    output logic          mxr_o,
    output logic          sd_o,
    output logic          ret_priv_o,
    output logic          fp_enable_o,
    output logic          guest_irq_en_o
);
    import gsr_pkg::*;

    localparam int CTX_LSB [NUM_CTX] = '{LSB_FS, LSB_VS};

    logic                in_guest;
    logic [NUM_CTX-1:0]  ctx_dirty;
    logic [1:0]          ctx_q [NUM_CTX];
    logic                sum_q, mxr_q;
    logic                unused_wbits;

    // Purpose: guest user and guest supervisor both count as guest modes.
    always_comb in_guest = (cur_mode == MODE_GUSER) || (cur_mode == MODE_GSUP);

    // Purpose: FP dirty only from guest modes; vector dirty from any write.
    always_comb begin
        ctx_dirty[0] = fp_reg_write & in_guest;
        ctx_dirty[1] = vec_reg_write;
    end

    gsr_stack u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_we       (csr_we),
        .sw_sie      (csr_wdata[BIT_SIE]),
        .sw_sie_m    (csr_wmask[BIT_SIE]),
        .sw_spie     (csr_wdata[BIT_SPIE]),
        .sw_spie_m   (csr_wmask[BIT_SPIE]),
        .sw_spp      (csr_wdata[BIT_SPP]),
        .sw_spp_m    (csr_wmask[BIT_SPP]),
        .trap_enter  (trap_enter),
        .prev_priv   (trap_prev_priv),
        .trap_return (trap_return),
        .sie         (sie_o),
        .spie        (spie_o),
        .spp         (spp_o)
    );

    generate
        for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
            gsr_ctx_field u_ctx (
                .clk      (clk),
                .rst_n    (rst_n),
                .sw_we    (csr_we),
                .sw_data  (csr_wdata[CTX_LSB[i] +: 2]),
                .sw_mask  (csr_wmask[CTX_LSB[i] +: 2]),
                .hw_dirty (ctx_dirty[i]),
                .q        (ctx_q[i])
            );
        end
    endgenerate

    // Purpose: plain read/write permission bits, updated by masked writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= 1'b0;
            mxr_q <= 1'b0;
        end else if (csr_we) begin
            if (csr_wmask[BIT_SUM]) sum_q <= csr_wdata[BIT_SUM];
            if (csr_wmask[BIT_MXR]) mxr_q <= csr_wdata[BIT_MXR];
        end
    end

    gsr_readmux #(
        .WIDE     (WIDE),
        .UXL_CODE (UXL_CODE),
        .BIG_END  (BIG_END)
    ) u_rd (
        .sie   (sie_o),
        .spie  (spie_o),
        .spp   (spp_o),
        .fs    (ctx_q[0]),
        .vs    (ctx_q[1]),
        .sum   (sum_q),
        .mxr   (mxr_q),
        .sd    (sd_o),
        .rdata (csr_rdata)
    );

    // Purpose: drive field outputs and the pipeline qualifiers.
    always_comb begin
        fs_o           = ctx_q[0];
        vs_o           = ctx_q[1];
        sum_o          = sum_q;
        mxr_o          = mxr_q;
        ret_priv_o     = spp_o;
        fp_enable_o    = (mach_fs != 2'b00) && (!in_guest || (ctx_q[0] != 2'b00));
        guest_irq_en_o = (cur_mode == MODE_GUSER) || ((cur_mode == MODE_GSUP) && sie_o);
    end

    // Purpose: gather write bits that map to no writable field.
    always_comb unused_wbits = ^{csr_wdata, csr_wmask};
endmodule

// File: rtl/gsr_checker.sv
// Property checker for guest_status_reg, attached by bind. Observes ports only.
module gsr_checker #(
    parameter bit  WIDE = 1'b1,
    localparam int DW   = WIDE ? 64 : 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] csr_rdata,
    input logic [1:0]    cur_mode,
    input logic          trap_enter,
    input logic          trap_prev_priv,
    input logic          trap_return,
    input logic          fp_reg_write,
    input logic          vec_reg_write,
    input logic          sie_o,
    input logic          spie_o,
    input logic          spp_o,
    input logic [1:0]    fs_o,
    input logic [1:0]    vs_o,
    input logic          guest_irq_en_o
);
    assert_xs_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[16:15] == 2'b00);

    assert_sd_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[DW-1] == (fs_o == 2'b11));

    assert_fp_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_reg_write && (cur_mode == 2'd1 || cur_mode == 2'd2)) |=> fs_o == 2'b11);

    assert_vec_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_reg_write |=> vs_o == 2'b11);

    assert_trap_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_enter |=> (!sie_o && spie_o == $past(sie_o) && spp_o == $past(trap_prev_priv)));

    assert_trap_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_return && !trap_enter) |=> (spie_o && sie_o == $past(spie_o)));

    assert_host_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 2'd0 || cur_mode == 2'd3) |-> !guest_irq_en_o);
endmodule

bind guest_status_reg gsr_checker #(.WIDE(WIDE)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .csr_rdata      (csr_rdata),
    .cur_mode       (cur_mode),
    .trap_enter     (trap_enter),
    .trap_prev_priv (trap_prev_priv),
    .trap_return    (trap_return),
    .fp_reg_write   (fp_reg_write),
    .vec_reg_write  (vec_reg_write),
    .sie_o          (sie_o),
    .spie_o         (spie_o),
    .spp_o          (spp_o),
    .fs_o           (fs_o),
    .vs_o           (vs_o),
    .guest_irq_en_o (guest_irq_en_o)
);

// File: tb/sim_guest_status_reg.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_guest_status_reg;
    localparam int DW = 64;
    localparam logic [63:0] HW_BITS = (64'd1 << 32) | (64'd1 << 6);
    localparam logic [63:0] ALL_WR  = (64'd1 << 1) | (64'd1 << 5) | (64'd1 << 8) |
                                      (64'd3 << 9) | (64'd3 << 13) | (64'd1 << 18) | (64'd1 << 19);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csr_we = 1'b0;
    logic [DW-1:0] csr_wdata = '0, csr_wmask = '0, csr_rdata;
    logic [1:0] cur_mode = 2'd0;
    logic trap_enter = 1'b0, trap_prev_priv = 1'b0, trap_return = 1'b0;
    logic fp_reg_write = 1'b0, vec_reg_write = 1'b0;
    logic [1:0] mach_fs = 2'd3;
    logic sie_o, spie_o, spp_o, sum_o, mxr_o, sd_o, ret_priv_o, fp_enable_o, guest_irq_en_o;
    logic [1:0] fs_o, vs_o;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    guest_status_reg #(.WIDE(1'b1), .UXL_CODE(2'd1), .BIG_END(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_wmask(csr_wmask), .csr_rdata(csr_rdata), .cur_mode(cur_mode),
        .trap_enter(trap_enter), .trap_prev_priv(trap_prev_priv),
        .trap_return(trap_return), .fp_reg_write(fp_reg_write),
        .vec_reg_write(vec_reg_write), .mach_fs(mach_fs), .sie_o(sie_o),
        .spie_o(spie_o), .spp_o(spp_o), .fs_o(fs_o), .vs_o(vs_o), .sum_o(sum_o),
        .mxr_o(mxr_o), .sd_o(sd_o), .ret_priv_o(ret_priv_o),
        .fp_enable_o(fp_enable_o), .guest_irq_en_o(guest_irq_en_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock with the current inputs, then clear strobes; sample at negedge.
    task automatic step();
        @(negedge clk);
        csr_we = 1'b0; trap_enter = 1'b0; trap_return = 1'b0;
        fp_reg_write = 1'b0; vec_reg_write = 1'b0;
    endtask

    task automatic csr_wr(input logic [63:0] d, input logic [63:0] m);
        csr_we = 1'b1; csr_wdata = d; csr_wmask = m;
        step();
    endtask

    task automatic t_reset();
        chk("R1 rdata", csr_rdata, HW_BITS);
        chk("R1 fields", {sie_o, spie_o, spp_o, fs_o, vs_o, sum_o, mxr_o}, 0);
    endtask

    task automatic t_masked_write();
        csr_wr('1, (64'd1 << 18) | (64'd1 << 1));
        chk("R2 partial", csr_rdata, HW_BITS | (64'd1 << 18) | (64'd1 << 1));
        csr_wr('1, '1);
        chk("R2 full", csr_rdata, HW_BITS | ALL_WR | (64'd1 << 63));
        csr_wr(64'd0, 64'd1 << 19);
        chk("R2 mxr clear", csr_rdata, HW_BITS | (ALL_WR & ~(64'd1 << 19)) | (64'd1 << 63));
    endtask

    task automatic t_readonly();
        csr_wr(64'd0, '1);
        chk("R3 zeros keep fixed bits", csr_rdata, HW_BITS);
        csr_wr(64'h7FFF_FFFC_7FF0_8000 | (64'd3 << 15), 64'h7FFF_FFFC_7FF0_8000 | (64'd3 << 15));
        chk("R3 ro bits ignored", csr_rdata, HW_BITS);
    endtask

    task automatic t_summary();
        csr_wr(64'd2 << 13, 64'd3 << 13);
        chk("R4 fs=2 no sd", {sd_o, csr_rdata[63]}, 2'b00);
        csr_wr(64'd3 << 13, 64'd3 << 13);
        chk("R4 fs=3 sd bit63", {sd_o, csr_rdata[63], csr_rdata[31]}, 3'b110);
        csr_wr(64'd0, 64'd3 << 13);
    endtask

    task automatic t_fp_dirty();
        cur_mode = 2'd0; fp_reg_write = 1'b1; step();
        chk("R5 host no effect", fs_o, 2'd0);
        cur_mode = 2'd2; fp_reg_write = 1'b1; step();
        chk("R5 guest sup dirty", fs_o, 2'd3);
        csr_wr(64'd1 << 13, 64'd3 << 13);
        cur_mode = 2'd1; fp_reg_write = 1'b1; step();
        chk("R5 guest user dirty", fs_o, 2'd3);
        cur_mode = 2'd0;
    endtask

    task automatic t_vec_dirty();
        csr_wr(64'd0, 64'd3 << 9);
        vec_reg_write = 1'b1; step();
        chk("R6 vs dirty", vs_o, 2'd3);
    endtask

    task automatic t_priority();
        cur_mode = 2'd2;
        csr_we = 1'b1; csr_wdata = (64'd1 << 13) | (64'd2 << 9); csr_wmask = (64'd3 << 13) | (64'd3 << 9);
        fp_reg_write = 1'b1; vec_reg_write = 1'b1; step();
        chk("R7 hw beats sw", {fs_o, vs_o}, 4'b1111);
        cur_mode = 2'd0;
    endtask

    task automatic t_trap_enter();
        csr_wr(64'd1 << 1, (64'd1 << 1) | (64'd1 << 5) | (64'd1 << 8));
        trap_enter = 1'b1; trap_prev_priv = 1'b1;
        csr_we = 1'b1; csr_wdata = 64'd1 << 1; csr_wmask = (64'd1 << 1) | (64'd1 << 5) | (64'd1 << 8);
        step();
        chk("R8 entry stack", {sie_o, spie_o, spp_o}, 3'b011);
        trap_enter = 1'b1; trap_prev_priv = 1'b0; step();
        chk("R8 nested entry", {sie_o, spie_o, spp_o}, 3'b000);
    endtask

    task automatic t_trap_return();
        csr_wr((64'd1 << 1) | (64'd1 << 8), (64'd1 << 1) | (64'd1 << 5) | (64'd1 << 8));
        chk("R9 ret priv before", ret_priv_o, 1'b1);
        trap_return = 1'b1; step();
        chk("R9 return spie=0", {sie_o, spie_o, ret_priv_o}, 3'b011);
        trap_return = 1'b1; step();
        chk("R9 return spie=1", {sie_o, spie_o}, 2'b11);
    endtask

    task automatic t_both();
        csr_wr(64'd1 << 1, (64'd1 << 1) | (64'd1 << 5));
        trap_enter = 1'b1; trap_return = 1'b1; trap_prev_priv = 1'b0; step();
        chk("R12 entry wins", {sie_o, spie_o, spp_o}, 3'b010);
    endtask

    task automatic t_fp_enable();
        csr_wr(64'd0, 64'd3 << 13);
        cur_mode = 2'd2; mach_fs = 2'd3; #1;
        chk("R10 guest fs=0", fp_enable_o, 1'b0);
        cur_mode = 2'd0; #1;
        chk("R10 host fs=0", fp_enable_o, 1'b1);
        mach_fs = 2'd0; #1;
        chk("R10 mach off", fp_enable_o, 1'b0);
        csr_wr(64'd1 << 13, 64'd3 << 13);
        cur_mode = 2'd1; mach_fs = 2'd2; #1;
        chk("R10 guest fs=1", fp_enable_o, 1'b1);
        mach_fs = 2'd0; #1;
        chk("R10 guest mach off", fp_enable_o, 1'b0);
        mach_fs = 2'd3; cur_mode = 2'd0;
    endtask

    task automatic t_irq();
        csr_wr(64'd0, 64'd1 << 1);
        cur_mode = 2'd2; #1; chk("R11 gsup sie=0", guest_irq_en_o, 1'b0);
        cur_mode = 2'd1; #1; chk("R11 guser", guest_irq_en_o, 1'b1);
        csr_wr(64'd1 << 1, 64'd1 << 1);
        cur_mode = 2'd2; #1; chk("R11 gsup sie=1", guest_irq_en_o, 1'b1);
        cur_mode = 2'd0; #1; chk("R11 host", guest_irq_en_o, 1'b0);
        cur_mode = 2'd3; #1; chk("R11 host3", guest_irq_en_o, 1'b0);
        cur_mode = 2'd0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked_write();
        t_readonly();
        t_summary();
        t_fp_dirty();
        t_vec_dirty();
        t_priority();
        t_trap_enter();
        t_trap_return();
        t_both();
        t_fp_enable();
        t_irq();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule